// File: doc/BRIEF.md
# Ring-Buffer DMA Channel

This block is one DMA channel. It copies words from a source location to a destination location through a simple bus master that uses a request and a grant. Software fills a set of configuration inputs: source address, destination address, word count, transfer mode, one increment enable per pointer, ring enable and abort interrupt enable. It then pulses an enable input. There is no separate start command. Once enabled, the channel moves one word at a time. Each word is a bus read at the source pointer followed by a bus write of that same data at the destination pointer. The word is held in an internal register between the read and the write.

In peripheral mode a word starts only while the peripheral requests service. The channel acknowledges each word it takes. In memory mode the channel runs without requests. With ring mode on, the channel reloads its start addresses and count at the end of the buffer and keeps going. It raises a half flag when half the buffer has been moved and a full flag when all of it has, so software can drain one half while the other half fills. It also raises flags for bus errors and for aborts. Every flag is sticky until software clears it with a write-one-to-clear input.

Top module: `ring_dma_channel`

## Requirements
- R1: After reset `ch_en`, `bus_req`, `per_ack`, `words_left` and all four `flags` bits are 0. Flag bit 0 is half, bit 1 is full, bit 2 is error, bit 3 is abort.
- R2: An `en_set` pulse while the channel is off and the stored count is nonzero turns `ch_en` on at the next edge, and the first read may be requested in that next cycle. With `cfg_mem2mem`=0 a read is requested only while `per_req` is 1. With `cfg_mem2mem`=1 reads are requested without `per_req`.
- R3: Each word is a read (`bus_we`=0) at the source pointer, then a write (`bus_we`=1) of the read data at the destination pointer. A request is held until `bus_gnt`. `per_ack` pulses in the cycle of an error-free granted read in peripheral mode.
- R4: After each completed write, the source pointer advances by one only if `cfg_src_inc` was stored as 1, and the destination pointer advances by one only if `cfg_dst_inc` was stored as 1.
- R5: `words_left` is loaded with the count on enable and drops by one on each completed write. It changes at no other time except a ring reload.
- R6: For a count N of at least 2, the half flag is set when floor(N/2) words have been written. For any count N, the full flag is set when N words have been written.
- R7: Without ring mode, `ch_en` falls after the last write. With ring mode, the pointers and count reload and the channel keeps running, and the half and full flags set again on every lap.
- R8: A granted access with `bus_err` sets the error flag and clears `ch_en`. `words_left` keeps its value, and no reload happens even in ring mode.
- R9: `en_set` with a stored count of 0 sets the error flag and leaves `ch_en` at 0.
- R10: `abort_req` while enabled clears `ch_en` at the next edge, and any access granted in that cycle is not counted. The abort flag is set only if `cfg_abort_ie` was stored as 1.
- R11: `cfg_we` while `ch_en` is 1 is ignored: addresses, count and modes stay as stored.
- R12: A 1 on a bit of `flag_clr` clears that flag. If the flag is set in the same cycle, the set wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_we | input | 1 | Store configuration inputs (only while off) |
| cfg_src | input | AW | Source start address |
| cfg_dst | input | AW | Destination start address |
| cfg_len | input | CW | Words per buffer |
| cfg_mem2mem | input | 1 | 1 = memory mode, 0 = peripheral mode |
| cfg_src_inc | input | 1 | Advance source pointer per word |
| cfg_dst_inc | input | 1 | Advance destination pointer per word |
| cfg_ring | input | 1 | Reload and continue at buffer end |
| cfg_abort_ie | input | 1 | Allow abort to set the abort flag |
| en_set | input | 1 | Enable pulse |
| abort_req | input | 1 | Stop the active transfer |
| per_req | input | 1 | Peripheral service request |
| per_ack | output | 1 | Peripheral word taken |
| bus_req | output | 1 | Bus access request |
| bus_we | output | 1 | 1 = write access |
| bus_addr | output | AW | Access address |
| bus_wdata | output | DW | Write data |
| bus_gnt | input | 1 | Access accepted and completed this cycle |
| bus_rdata | input | DW | Read data, valid with grant |
| bus_err | input | 1 | Access error, valid with grant |
| ch_en | output | 1 | Channel enabled |
| words_left | output | CW | Words remaining in this lap |
| flags | output | 4 | Sticky half, full, error, abort |
| flag_clr | input | 4 | Write-one-to-clear for flags |

## Verification
The bench builds the channel with its defaults: 16-bit addresses and data, an 8-bit count and a pointer step of one. Buffers of 3 to 9 words therefore close several ring laps within a few hundred cycles. A 256-word window of the address space serves as bus memory, so fixed and advancing pointers both land on known data. Grants and peripheral requests follow a pseudo-random pattern. This makes stalls between the read and the write, and coincidences of abort, error or configuration writes with granted accesses, reachable in short runs.

// File: rtl/ring_dma_pkg.sv
package ring_dma_pkg;

   typedef enum logic {
      PH_RD = 1'b0,
      PH_WR = 1'b1
   } rdma_phase_e;

   localparam int FLAG_N     = 4;
   localparam int FLAG_HALF  = 0;
   localparam int FLAG_FULL  = 1;
   localparam int FLAG_ERR   = 2;
   localparam int FLAG_ABORT = 3;

   typedef struct packed {
      logic abort;
      logic err;
      logic full;
      logic half;
   } rdma_flags_t;

endpackage

// File: rtl/rdma_ptr.sv
module rdma_ptr #(
   parameter int AW   = 16,
   parameter int STEP = 1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [AW-1:0] base,
   input  logic          adv,
   output logic [AW-1:0] ptr
);
   logic [AW-1:0] ptr_q;
   logic [AW-1:0] ptr_nx;

   generate
      if (STEP < 1) begin : g_bad_step
         $error("rdma_ptr: STEP must be positive");
      end
      if (STEP == 1) begin : g_unit
         assign ptr_nx = ptr_q + 1'b1;
      end else begin : g_wide
         localparam logic [AW-1:0] STEP_V = AW'(STEP);
         assign ptr_nx = ptr_q + STEP_V;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    ptr_q <= '0;
      else if (load) ptr_q <= base;
      else if (adv)  ptr_q <= ptr_nx;
   end

   assign ptr = ptr_q;
endmodule

// File: rtl/rdma_count.sv
module rdma_count #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic [CW-1:0] len,
   input  logic          dec,
   output logic [CW-1:0] left,
   output logic          half_hit,
   output logic          last_hit
);
   logic [CW-1:0] left_q;
   logic [CW-1:0] half_mark;
   logic [CW-1:0] left_dn;

   assign half_mark = len - (len >> 1);
   assign left_dn   = left_q - 1'b1;
   assign last_hit  = dec && (left_q == CW'(1));
   assign half_hit  = dec && (len > CW'(1)) && (left_dn == half_mark);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    left_q <= '0;
      else if (load) left_q <= len;
      else if (dec)  left_q <= left_dn;
   end

   assign left = left_q;
endmodule

// File: rtl/rdma_flags.sv
module rdma_flags #(
   parameter int NF = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [NF-1:0] set,
   input  logic [NF-1:0] clr,
   output logic [NF-1:0] flags
);
   generate
      for (genvar i = 0; i < NF; i++) begin : g_bit
         logic f_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)      f_q <= 1'b0;
            else if (set[i]) f_q <= 1'b1;
            else if (clr[i]) f_q <= 1'b0;
         end
         assign flags[i] = f_q;
      end
   endgenerate
endmodule

// File: rtl/rdma_seq.sv
module rdma_seq
   import ring_dma_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic m2m,
   input  logic ring,
   input  logic per_req,
   input  logic bus_gnt,
   input  logic bus_err,
   input  logic abort_req,
   input  logic last_hit,
   output logic ch_en,
   output logic wr_phase,
   output logic bus_req,
   output logic bus_we,
   output logic rd_ok,
   output logic wr_ok,
   output logic acc_err,
   output logic abort_hit
);
   rdma_phase_e ph_q;
   logic        en_q;
   logic        live;

   assign bus_req   = en_q && (ph_q == PH_WR || m2m || per_req);
   assign bus_we    = en_q && (ph_q == PH_WR);
   assign live      = bus_req && bus_gnt && !abort_req;
   assign acc_err   = live && bus_err;
   assign rd_ok     = live && !bus_err && (ph_q == PH_RD);
   assign wr_ok     = live && !bus_err && (ph_q == PH_WR);
   assign abort_hit = en_q && abort_req;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         en_q <= 1'b0;
         ph_q <= PH_RD;
      end else if (abort_hit || acc_err) begin
         en_q <= 1'b0;
         ph_q <= PH_RD;
      end else if (rd_ok) begin
         ph_q <= PH_WR;
      end else if (wr_ok) begin
         ph_q <= PH_RD;
         if (last_hit && !ring) en_q <= 1'b0;
      end else if (start) begin
         en_q <= 1'b1;
         ph_q <= PH_RD;
      end
   end

   assign ch_en    = en_q;
   assign wr_phase = (ph_q == PH_WR);
endmodule

// File: rtl/ring_dma_channel.sv
module ring_dma_channel
   import ring_dma_pkg::*;
#(
   parameter int AW        = 16,
   parameter int DW        = 16,
   parameter int CW        = 8,
   parameter int ADDR_STEP = 1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                cfg_we,
   input  logic [AW-1:0]       cfg_src,
   input  logic [AW-1:0]       cfg_dst,
   input  logic [CW-1:0]       cfg_len,
   input  logic                cfg_mem2mem,
   input  logic                cfg_src_inc,
   input  logic                cfg_dst_inc,
   input  logic                cfg_ring,
   input  logic                cfg_abort_ie,
   input  logic                en_set,
   input  logic                abort_req,
   input  logic                per_req,
   output logic                per_ack,
   output logic                bus_req,
   output logic                bus_we,
   output logic [AW-1:0]       bus_addr,
   output logic [DW-1:0]       bus_wdata,
   input  logic                bus_gnt,
   input  logic [DW-1:0]       bus_rdata,
   input  logic                bus_err,
   output logic                ch_en,
   output logic [CW-1:0]       words_left,
   output logic [FLAG_N-1:0]   flags,
   input  logic [FLAG_N-1:0]   flag_clr
);
   localparam int NPTR = 2;

   generate
      if (AW < 2 || DW < 1 || CW < 2) begin : g_bad_width
         $error("ring_dma_channel: widths out of range");
      end
   endgenerate

   // stored configuration
   logic [AW-1:0] src_q, dst_q;
   logic [CW-1:0] len_q;
   logic          m2m_q, sinc_q, dinc_q, ring_q, aie_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src_q  <= '0;
         dst_q  <= '0;
         len_q  <= '0;
         m2m_q  <= 1'b0;
         sinc_q <= 1'b0;
         dinc_q <= 1'b0;
         ring_q <= 1'b0;
         aie_q  <= 1'b0;
      end else if (cfg_we && !ch_en) begin
         src_q  <= cfg_src;
         dst_q  <= cfg_dst;
         len_q  <= cfg_len;
         m2m_q  <= cfg_mem2mem;
         sinc_q <= cfg_src_inc;
         dinc_q <= cfg_dst_inc;
         ring_q <= cfg_ring;
         aie_q  <= cfg_abort_ie;
      end
   end

   logic start, zero_err, reload;
   logic wr_phase, rd_ok, wr_ok, acc_err, abort_hit;
   logic half_hit, last_hit;

   assign start    = en_set && !ch_en && (len_q != '0);
   assign zero_err = en_set && !ch_en && (len_q == '0);
   assign reload   = last_hit && ring_q;

   rdma_seq u_seq (
      .clk       (clk),
      .rst_n     (rst_n),
      .start     (start),
      .m2m       (m2m_q),
      .ring      (ring_q),
      .per_req   (per_req),
      .bus_gnt   (bus_gnt),
      .bus_err   (bus_err),
      .abort_req (abort_req),
      .last_hit  (last_hit),
      .ch_en     (ch_en),
      .wr_phase  (wr_phase),
      .bus_req   (bus_req),
      .bus_we    (bus_we),
      .rd_ok     (rd_ok),
      .wr_ok     (wr_ok),
      .acc_err   (acc_err),
      .abort_hit (abort_hit)
   );

   rdma_count #(.CW(CW)) u_count (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (start || reload),
      .len      (len_q),
      .dec      (wr_ok),
      .left     (words_left),
      .half_hit (half_hit),
      .last_hit (last_hit)
   );

   // pointer 0 = source, pointer 1 = destination
   logic [AW-1:0] ptr_base [NPTR];
   logic [AW-1:0] ptr_cur  [NPTR];
   logic          ptr_inc  [NPTR];

   assign ptr_base[0] = src_q;
   assign ptr_base[1] = dst_q;
   assign ptr_inc[0]  = sinc_q;
   assign ptr_inc[1]  = dinc_q;

   generate
      for (genvar g = 0; g < NPTR; g++) begin : g_ptr
         rdma_ptr #(.AW(AW), .STEP(ADDR_STEP)) u_ptr (
            .clk   (clk),
            .rst_n (rst_n),
            .load  (start || reload),
            .base  (ptr_base[g]),
            .adv   (wr_ok && ptr_inc[g]),
            .ptr   (ptr_cur[g])
         );
      end
   endgenerate

   assign bus_addr = wr_phase ? ptr_cur[1] : ptr_cur[0];

   logic [DW-1:0] hold_q;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)     hold_q <= '0;
      else if (rd_ok) hold_q <= bus_rdata;
   end
   assign bus_wdata = hold_q;
   assign per_ack   = rd_ok && !m2m_q;

   rdma_flags_t flag_set;
   assign flag_set.half  = half_hit;
   assign flag_set.full  = last_hit;
   assign flag_set.err   = acc_err || zero_err;
   assign flag_set.abort = abort_hit && aie_q;

   rdma_flags #(.NF(FLAG_N)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (flag_set),
      .clr   (flag_clr),
      .flags (flags)
   );
endmodule

// File: rtl/ring_dma_checker.sv
module ring_dma_checker #(
   parameter int AW = 16,
   parameter int CW = 8
) (
   input logic          clk,
   input logic          rst_n,
   input logic          cfg_we,
   input logic          en_set,
   input logic          abort_req,
   input logic          bus_req,
   input logic          bus_we,
   input logic          bus_gnt,
   input logic          bus_err,
   input logic          ch_en,
   input logic [CW-1:0] words_left,
   input logic [3:0]    flags,
   input logic [AW-1:0] src_q,
   input logic [CW-1:0] len_q,
   input logic          aie_q
);
   // R8
   err_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && bus_req && bus_gnt && bus_err && !abort_req)
      |=> (!ch_en && flags[2] && $stable(words_left)));

   // R10
   abort_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && abort_req) |=> !ch_en);

   // R10
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && abort_req && !aie_q && !flags[3]) |=> !flags[3]);

   // R11
   cfg_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && cfg_we) |=> ($stable(len_q) && $stable(src_q)));

   // R3
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && bus_req && !bus_we && bus_gnt && !bus_err && !abort_req)
      |=> (ch_en && bus_req && bus_we));

   // R5
   left_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (ch_en && !(bus_req && bus_we && bus_gnt)) |=> $stable(words_left));

   // R9
   zero_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!ch_en && en_set && len_q == '0) |=> (!ch_en && flags[2]));
endmodule

bind ring_dma_channel ring_dma_checker #(.AW(AW), .CW(CW)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .cfg_we     (cfg_we),
   .en_set     (en_set),
   .abort_req  (abort_req),
   .bus_req    (bus_req),
   .bus_we     (bus_we),
   .bus_gnt    (bus_gnt),
   .bus_err    (bus_err),
   .ch_en      (ch_en),
   .words_left (words_left),
   .flags      (flags),
   .src_q      (src_q),
   .len_q      (len_q),
   .aie_q      (aie_q)
);

// File: tb/ring_dma_channel_test.sv
`timescale 1ns/1ps
module ring_dma_channel_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_we = 0, cfg_mem2mem = 0, cfg_src_inc = 0, cfg_dst_inc = 0;
   logic        cfg_ring = 0, cfg_abort_ie = 0, en_set = 0, abort_req = 0;
   logic [15:0] cfg_src = 0, cfg_dst = 0;
   logic [7:0]  cfg_len = 0;
   logic        per_req, per_ack, bus_req, bus_we, bus_gnt, bus_err = 0, ch_en;
   logic [15:0] bus_addr, bus_wdata, bus_rdata;
   logic [7:0]  words_left;
   logic [3:0]  flags;
   logic [3:0]  flag_clr = 0;
   logic [15:0] lfsr = 16'hACE1;
   logic        req_on = 0;
   logic [15:0] mem [256];
   int          compared = 0, mismatched = 0;
   string       cur = "R1";

   always #2.5 clk = ~clk;

   assign bus_gnt   = lfsr[0] | lfsr[3];
   assign per_req   = req_on & lfsr[5];
   assign bus_rdata = mem[bus_addr[7:0]];

   ring_dma_channel uut (.*);

   // reference model state
   logic        m_en, m_ph, m_m2m, m_sinc, m_dinc, m_ring, m_aie;
   logic [15:0] m_src, m_dst, m_csrc, m_cdst, m_hold;
   logic [7:0]  m_left, m_clen;
   logic [3:0]  m_flags;

   function automatic logic exp_req();
      return m_en && (m_ph || m_m2m || per_req);
   endfunction

   always @(negedge clk) lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};

   always @(posedge clk) begin
      logic [3:0] st;
      logic       was_en;
      st = 0;
      was_en = m_en;
      if (!rst_n) begin
         m_en = 0; m_ph = 0; m_src = 0; m_dst = 0; m_hold = 0; m_left = 0;
         m_flags = 0; m_csrc = 0; m_cdst = 0; m_clen = 0;
         m_m2m = 0; m_sinc = 0; m_dinc = 0; m_ring = 0; m_aie = 0;
      end else begin
         if (m_en && abort_req) begin
            m_en = 0; m_ph = 0;
            if (m_aie) st[3] = 1;
         end else if (exp_req() && bus_gnt) begin
            if (bus_err) begin
               st[2] = 1; m_en = 0; m_ph = 0;
            end else if (!m_ph) begin
               m_hold = mem[m_src[7:0]]; m_ph = 1;
            end else begin
               mem[m_dst[7:0]] = m_hold; m_ph = 0;
               if (m_sinc) m_src = m_src + 1;
               if (m_dinc) m_dst = m_dst + 1;
               m_left = m_left - 1;
               if (m_clen >= 2 && m_left == m_clen - m_clen / 2) st[0] = 1;
               if (m_left == 0) begin
                  st[1] = 1;
                  if (m_ring) begin
                     m_src = m_csrc; m_dst = m_cdst; m_left = m_clen;
                  end else m_en = 0;
               end
            end
         end else if (!m_en && en_set) begin
            if (m_clen == 0) st[2] = 1;
            else begin
               m_en = 1; m_ph = 0; m_src = m_csrc; m_dst = m_cdst; m_left = m_clen;
            end
         end
         if (!was_en && cfg_we) begin
            m_csrc = cfg_src; m_cdst = cfg_dst; m_clen = cfg_len; m_m2m = cfg_mem2mem;
            m_sinc = cfg_src_inc; m_dinc = cfg_dst_inc; m_ring = cfg_ring; m_aie = cfg_abort_ie;
         end
         m_flags = (m_flags & ~flag_clr) | st;
      end
   end

   task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string what);
      compared++;
      if (act !== exp) begin
         mismatched++;
         $display("FAIL %s %s act=%h exp=%h t=%0t", cur, what, act, exp, $time);
      end
   endtask

   // compare every cycle, away from the active edge
   always @(negedge clk) begin
      #1;
      if (rst_n) begin
         chk(16'(ch_en), 16'(m_en), "ch_en");
         chk(16'(bus_req), 16'(exp_req()), "bus_req");
         chk(16'(words_left), 16'(m_left), "words_left");
         chk(16'(flags), 16'(m_flags), "flags");
         chk(16'(per_ack), 16'(exp_req() && !m_ph && !m_m2m && bus_gnt && !bus_err && !abort_req), "per_ack");
         if (exp_req()) begin
            chk(16'(bus_we), 16'(m_ph), "bus_we");
            chk(bus_addr, m_ph ? m_dst : m_src, "bus_addr");
            if (m_ph) chk(bus_wdata, m_hold, "bus_wdata");
         end
      end
   end

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic config_ch(input logic [15:0] s, input logic [15:0] d, input logic [7:0] n,
                            input logic mm, input logic si, input logic di,
                            input logic rg, input logic ie);
      @(negedge clk);
      cfg_src = s; cfg_dst = d; cfg_len = n; cfg_mem2mem = mm;
      cfg_src_inc = si; cfg_dst_inc = di; cfg_ring = rg; cfg_abort_ie = ie; cfg_we = 1;
      @(negedge clk);
      cfg_we = 0;
   endtask

   task automatic pulse_en();
      @(negedge clk); en_set = 1;
      @(negedge clk); en_set = 0;
   endtask

   task automatic pulse_abort();
      @(negedge clk); abort_req = 1;
      @(negedge clk); abort_req = 0;
   endtask

   task automatic pulse_clr(input logic [3:0] c);
      @(negedge clk); flag_clr = c;
      @(negedge clk); flag_clr = 0;
   endtask

   task automatic wait_off(input int lim);
      for (int i = 0; i < lim && m_en; i++) @(negedge clk);
   endtask

   initial begin
      for (int i = 0; i < 256; i++) mem[i] = 16'(i * 37 + 5);
      cycles(3);
      cur = "R1";
      rst_n = 1;
      cycles(3);
      cur = "R9";
      pulse_en();
      cycles(2);
      cur = "R12";
      pulse_clr(4'b0100);
      cycles(2);
      cur = "R2/R3";
      req_on = 1;
      config_ch(16'h0010, 16'h0040, 8'd6, 0, 0, 1, 0, 0);
      pulse_en();
      wait_off(200);
      cycles(3);
      cur = "R4/R5";
      config_ch(16'h0020, 16'h0080, 8'd3, 1, 1, 0, 0, 0);
      pulse_en();
      wait_off(200);
      cycles(3);
      cur = "R7";
      pulse_clr(4'b1111);
      config_ch(16'h0030, 16'h0090, 8'd5, 1, 1, 1, 1, 1);
      pulse_en();
      cycles(60);
      cur = "R11";
      config_ch(16'h00F0, 16'h0001, 8'd2, 0, 0, 0, 0, 0);
      cycles(20);
      cur = "R12";
      pulse_clr(4'b0011);
      cycles(20);
      cur = "R10";
      pulse_abort();
      cycles(3);
      cur = "R6";
      pulse_clr(4'b1111);
      config_ch(16'h0050, 16'h00A0, 8'd7, 0, 1, 1, 0, 0);
      pulse_en();
      wait_off(300);
      cycles(3);
      cur = "R10";
      config_ch(16'h0060, 16'h00B0, 8'd9, 1, 1, 1, 0, 0);
      pulse_en();
      cycles(8);
      pulse_abort();
      cycles(3);
      cur = "R8";
      config_ch(16'h0070, 16'h00C0, 8'd8, 1, 1, 1, 1, 1);
      pulse_en();
      cycles(10);
      @(negedge clk); bus_err = 1;
      cycles(3);
      bus_err = 0;
      cycles(5);
      req_on = 0;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      mismatched++;
      $display("FAIL watchdog expired in %s act=running exp=done", cur);
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
   end
endmodule